// File: doc/BRIEF.md
# Flash Status Bit Reporter

This block builds the read word a dual-plane flash model returns while an internal program or erase cycle runs. Each read access is qualified by a strobe. The block decodes the plane and the sector from the read address. A read of a plane with no running cycle returns the array word unchanged. A read of a busy plane returns a status word. In that word bit 7 is the polling bit, bit 6 alternates between successive reads, and every bit that carries no status reads high. A sector that has been placed in erase suspend answers on bit 2, which alternates between successive reads of that sector.

The two planes are tracked separately. One plane can report status while a read of the other plane returns real data in the same period. An active-high pull-down request models the open-drain ready/busy line. It asserts while either plane is busy, so several devices can share one wired line. The data-bus enable follows chip enable and output enable.

The read word is registered on the clock edge where the strobe is first seen high. It stays on `dataOut` until the next strobe rising edge. The plane is the top address bit. The sector is the top `SECT_W` address bits.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset, `dataOut` is 16'hFFFF, `rbPullLow` is 0, and the bit 6 and bit 2 alternation states of every plane start at 0.
- R2: A read whose plane (address bit 19) is idle and whose sector is not suspended returns `arrayData` on `dataOut` in the cycle after the clock edge that first samples the strobe high.
- R3: In a busy plane whose operation is a program, a read at `lastPgmAddr` returns the inverse of `lastPgmD7` on bit 7. A read at any other address of that plane returns 0 on bit 7.
- R4: In a busy plane whose operation is an erase (`planeErase` set for that plane), bit 7 reads 0.
- R5: Bit 6 of a busy-plane read equals that plane's alternation state, which starts at 0 and inverts after every read of that busy plane. Reads of an idle plane leave it unchanged. Each plane has its own state.
- R6: In a status word, bits 15..8, 5..3, 1 and 0 read 1.
- R7: While `suspValid` is set, a read whose address bits 19..15 equal `suspSector` returns a status word whose bit 2 is the suspend alternation state. That state starts at 0 and inverts after each such read. If the plane is idle, bits 7 and 6 read 1.
- R8: While one plane is busy, a read of the other plane returns true array data.
- R9: A strobe held high for several cycles counts as one read. The word is captured once, and each alternation state inverts at most once.
- R10: `rbPullLow` is 1 in the cycle after any plane is busy and 0 in the cycle after both planes are idle.
- R11: `dataOe` is 1 only while `ceN` and `oeN` are both low. Otherwise the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| rdStrobe | input | 1 | Read access strobe; its rising edge marks one read |
| rdAddr | input | 20 | Read word address |
| arrayData | input | 16 | Array word at `rdAddr` |
| planeBusy | input | 2 | Per-plane internal cycle running |
| planeErase | input | 2 | Per-plane operation type: 1 erase, 0 program |
| lastPgmAddr | input | 20 | Address of the word being programmed |
| lastPgmD7 | input | 1 | Bit 7 of the word being programmed |
| suspValid | input | 1 | A sector erase is suspended |
| suspSector | input | 5 | Suspended sector number |
| dataOut | output | 16 | Read word |
| dataOe | output | 1 | Data bus driven; 0 means high impedance |
| rbPullLow | output | 1 | Open-drain ready/busy pull-down request |

## Verification
The assertions assume that `arrayData`, the busy flags and the suspend inputs stay stable from the strobe rising edge through the capturing clock edge. The stimulus changes them only on the falling clock edge, between reads. The assertions also assume the strobe is low while reset is applied. The bench raises the strobe only after reset is released and lowers it after every access.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int PLANE_W = 1;
  localparam int NPLANES = 1 << PLANE_W;

  typedef struct packed {
    logic                capture;
    logic                busyRead;
    logic                suspRead;
    logic                pgmHit;
    logic                flip2;
    logic [NPLANES-1:0]  flip6;
    logic [PLANE_W-1:0]  planeSel;
  } fsrStrobes_t;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [NPLANES-1:0] planeBusy,
  input  logic               suspValid,
  input  logic [SECT_W-1:0]  suspSector,
  input  logic [ADDR_W-1:0]  lastPgmAddr,
  output fsrStrobes_t        strobes,
  output logic               rbPullLow
);
  logic               rdStrobeQ;
  logic               rdRise;
  logic [PLANE_W-1:0] planeSel;
  logic [SECT_W-1:0]  sectSel;
  logic               busyHit;
  logic               suspHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStrobeQ <= 1'b0;
      rbPullLow <= 1'b0;
    end else begin
      rdStrobeQ <= rdStrobe;
      rbPullLow <= |planeBusy;
    end
  end

  always_comb begin
    rdRise   = rdStrobe && !rdStrobeQ;
    planeSel = rdAddr[ADDR_W-1 -: PLANE_W];
    sectSel  = rdAddr[ADDR_W-1 -: SECT_W];
    busyHit  = planeBusy[planeSel];
    suspHit  = suspValid && (sectSel == suspSector);

    strobes          = '0;
    strobes.capture  = rdRise;
    strobes.busyRead = busyHit;
    strobes.suspRead = suspHit;
    strobes.pgmHit   = (rdAddr == lastPgmAddr);
    strobes.flip2    = rdRise && suspHit;
    strobes.planeSel = planeSel;
    if (rdRise && busyHit) strobes.flip6[planeSel] = 1'b1;
  end

  // R10: the pull-down request follows the busy flags one cycle later
  p_rb_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|planeBusy) |=> rbPullLow);
  p_rb_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(|planeBusy) |=> !rbPullLow);
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  fsrStrobes_t        strobes,
  input  logic [DATA_W-1:0]  arrayData,
  input  logic [NPLANES-1:0] planeErase,
  input  logic               lastPgmD7,
  output logic [DATA_W-1:0]  rdWord
);
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int SUSP_BIT = 2;

  logic [NPLANES-1:0] tog6;
  logic               tog2;
  logic [DATA_W-1:0]  nextWord;

  always_comb begin
    if (!strobes.busyRead && !strobes.suspRead) begin
      nextWord = arrayData;
    end else begin
      nextWord = '1;
      if (strobes.busyRead) begin
        nextWord[TOG_BIT] = tog6[strobes.planeSel];
        if (planeErase[strobes.planeSel])
          nextWord[POLL_BIT] = 1'b0;
        else
          nextWord[POLL_BIT] = strobes.pgmHit ? !lastPgmD7 : 1'b0;
      end
      if (strobes.suspRead) nextWord[SUSP_BIT] = tog2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWord <= '1;
      tog2   <= 1'b0;
    end else begin
      if (strobes.capture) rdWord <= nextWord;
      if (strobes.flip2)   tog2   <= !tog2;
    end
  end

  for (genvar p = 0; p < NPLANES; p++) begin : g_tog
    always_ff @(posedge clk) begin
      if (!rstN)                 tog6[p] <= 1'b0;
      else if (strobes.flip6[p]) tog6[p] <= !tog6[p];
    end

    // R5: a plane's alternation state moves only on a read of that busy plane
    p_tog6_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.flip6[p] |=> $stable(tog6[p]));
    p_tog6_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
      strobes.flip6[p] |=> (tog6[p] != $past(tog6[p])));
  end

  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.busyRead && !strobes.suspRead)
    |=> (rdWord == $past(arrayData)));
  p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.busyRead && planeErase[strobes.planeSel])
    |=> !rdWord[POLL_BIT]);
  p_fill_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (strobes.busyRead || strobes.suspRead))
    |=> (&{rdWord[DATA_W-1:8], rdWord[5:3], rdWord[1:0]}));
  p_tog2_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flip2 |=> (tog2 != $past(tog2)));
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(rdWord));
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ceN,
  input  logic               oeN,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  arrayData,
  input  logic [NPLANES-1:0] planeBusy,
  input  logic [NPLANES-1:0] planeErase,
  input  logic [ADDR_W-1:0]  lastPgmAddr,
  input  logic               lastPgmD7,
  input  logic               suspValid,
  input  logic [SECT_W-1:0]  suspSector,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe,
  output logic               rbPullLow
);
  fsrStrobes_t strobes;

  fsr_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdStrobe   (rdStrobe),
    .rdAddr     (rdAddr),
    .planeBusy  (planeBusy),
    .suspValid  (suspValid),
    .suspSector (suspSector),
    .lastPgmAddr(lastPgmAddr),
    .strobes    (strobes),
    .rbPullLow  (rbPullLow)
  );

  fsr_datapath #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .arrayData (arrayData),
    .planeErase(planeErase),
    .lastPgmD7 (lastPgmD7),
    .rdWord    (dataOut)
  );

  assign dataOe = !ceN && !oeN;
endmodule

// File: tb/flash_status_reporter_tb.sv
module flash_status_reporter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1;
  logic        rdStrobe = 1'b0;
  logic [19:0] rdAddr = '0;
  logic [15:0] arrayData;
  logic [1:0]  planeBusy = '0, planeErase = '0;
  logic [19:0] lastPgmAddr = '0;
  logic        lastPgmD7 = 1'b0;
  logic        suspValid = 1'b0;
  logic [4:0]  suspSector = '0;
  logic [15:0] dataOut;
  logic        dataOe, rbPullLow;

  int errors = 0;
  int checks = 0;
  logic [1:0] mTog6 = '0;
  logic       mTog2 = 1'b0;

  always #10 clk = !clk;

  function automatic logic [15:0] memFn(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'hA5C};
  endfunction

  assign arrayData = memFn(rdAddr);

  flash_status_reporter u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .arrayData(arrayData), .planeBusy(planeBusy),
    .planeErase(planeErase), .lastPgmAddr(lastPgmAddr), .lastPgmD7(lastPgmD7),
    .suspValid(suspValid), .suspSector(suspSector), .dataOut(dataOut),
    .dataOe(dataOe), .rbPullLow(rbPullLow)
  );

  function automatic logic [15:0] expWord(input logic [19:0] a);
    logic p = a[19];
    logic inSusp = suspValid && (a[19:15] == suspSector);
    logic [15:0] w;
    if (!planeBusy[p] && !inSusp) return memFn(a);
    w = 16'hFFFF;
    if (planeBusy[p]) begin
      w[6] = mTog6[p];
      w[7] = planeErase[p] ? 1'b0 : ((a == lastPgmAddr) ? !lastPgmD7 : 1'b0);
    end
    if (inSusp) w[2] = mTog2;
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelAdvance(input logic [19:0] a);
    if (planeBusy[a[19]]) mTog6[a[19]] = !mTog6[a[19]];
    if (suspValid && a[19:15] == suspSector) mTog2 = !mTog2;
  endtask

  // one read: strobe high for `hold` cycles, sampled on falling edges
  task automatic doRead(input string tag, input logic [19:0] a, input int hold);
    logic [15:0] e;
    @(negedge clk);
    rdAddr = a;
    rdStrobe = 1'b1;
    e = expWord(a);
    modelAdvance(a);
    repeat (hold) @(negedge clk);
    rdStrobe = 1'b0;
    check(tag, dataOut, e);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 word", dataOut, 16'hFFFF);
    check("R1 rb", {15'd0, rbPullLow}, 16'd0);

    // R2 idle pass-through
    doRead("R2 idle", 20'h12345, 1);
    doRead("R2 idle", 20'h9ABCD, 1);

    // R3/R5 program on plane 0
    lastPgmAddr = 20'h01234;
    lastPgmD7 = 1'b1;
    planeBusy = 2'b01;
    planeErase = 2'b00;
    @(negedge clk);
    check("R10 busy", {15'd0, rbPullLow}, 16'd1);
    doRead("R3 pgm addr", 20'h01234, 1);
    doRead("R5 toggle", 20'h01234, 1);
    doRead("R3 other addr", 20'h05555, 1);
    doRead("R8 other plane", 20'hC0F0F, 1);
    doRead("R5 after idle read", 20'h01234, 1);
    // R9 held strobe counts once
    doRead("R9 held", 20'h01234, 4);
    doRead("R9 next", 20'h01234, 1);
    lastPgmD7 = 1'b0;
    doRead("R3 d7 zero", 20'h01234, 1);

    // R4 erase on plane 1, plane 0 idle
    planeBusy = 2'b10;
    planeErase = 2'b10;
    doRead("R4 erase", 20'h8AAAA, 1);
    doRead("R4 erase", 20'hF0001, 1);
    doRead("R6 status fill", 20'h80000, 1);
    doRead("R8 plane0 data", 20'h01234, 1);

    // R7 suspend on plane 1 sector 0x18, plane idle
    planeBusy = 2'b00;
    @(negedge clk);
    check("R10 idle", {15'd0, rbPullLow}, 16'd0);
    suspValid = 1'b1;
    suspSector = 5'h18;
    doRead("R7 susp", 20'hC0123, 1);
    doRead("R7 susp", 20'hC7FFF, 1);
    doRead("R7 susp held", 20'hC0001, 3);
    doRead("R7 susp next", 20'hC0001, 1);
    doRead("R2 other sector", 20'hC8000, 1);
    suspValid = 1'b0;

    // R11 bus enable
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      {ceN, oeN} = k[1:0];
      #1;
      check("R11 oe", {15'd0, dataOe}, {15'd0, (k == 0)});
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        planeBusy = 2'($urandom);
        planeErase = 2'($urandom);
        lastPgmAddr = 20'($urandom);
        lastPgmD7 = 1'($urandom);
        suspValid = 1'($urandom);
        suspSector = 5'($urandom);
        @(negedge clk);
        check("R10 rand", {15'd0, rbPullLow}, {15'd0, |planeBusy});
      end
      a = 20'($urandom);
      if ($urandom_range(0, 3) == 0) a = lastPgmAddr;
      if ($urandom_range(0, 3) == 0) a[19:15] = suspSector;
      doRead("R2/R3/R4/R5/R7 rand", a, $urandom_range(1, 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule